// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a requester and a memory or peripheral port and provides two 32 MB alias windows. Each 32-bit word of an alias window stands for one bit of a target region. An alias read becomes one read of the target, and the addressed bit comes back in bit 0 of the response. An alias write becomes a read-modify-write. The bridge reads the target, changes the one addressed bit, and writes the full access back. The master port stays locked from the read until the write-back.

The alias window at 0x2200_0000 covers target base 0x2000_0000, and the window at 0x4200_0000 covers target base 0x4000_0000. The bridge accepts only alias traffic. It answers any other address, and any illegal size, with an error and does not touch the master port. Both ports use a hold-until-ready handshake. The requester holds its request until `sReady` pulses for one cycle. The bridge holds each master request until `mReady`.

Top module: `bitband_bridge`

## Requirements
- R1: An address whose bits [31:25] match a window base maps to the target byte address `targetBase | (addr[24:0] >> 5)`. The window at 0x2200_0000 uses target base 0x2000_0000, and the window at 0x4200_0000 uses 0x4000_0000.
- R2: The size code on `sSize`/`mSize` gives the access width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. The target address is rounded down to a multiple of the access size. The bit index is `(addr >> 2) & (8*bytes - 1)`. The target bytes lie little-endian in the low lanes of the data buses, so byte n is bits [8n+7:8n].
- R3: An alias read makes exactly one master read. A successful read returns the selected bit in `sRdata[0]` with bits [31:1] zero.
- R4: An alias write makes one master read and then one master write to the same address and size. The written data equals the fetched data with only the selected bit changed.
- R5: On a write, `sWdata[0]`=1 sets the bit and 0 clears it. All other write-data bits have no effect.
- R6: Size code 3 is illegal. It gets an error response and causes no master access.
- R7: If the master read reports an error, the bridge returns an error and issues no write-back.
- R8: If the write-back reports an error, the bridge returns an error.
- R9: `mLock` is high during both master accesses of a read-modify-write and low during the master access of a plain read.
- R10: `sReady` stays low while a master access is in progress and is a single-cycle pulse. On an error response, `sRdata` is zero.
- R11: An address outside both windows gets an error response with no master access.
- R12: While reset is held, `sReady`, `mReq` and `mLock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| sReq | input | 1 | Slave request, held until sReady |
| sAddr | input | 32 | Alias byte address |
| sWrite | input | 1 | 1 = write, 0 = read |
| sSize | input | 2 | Size code (0:1B, 1:2B, 2:4B) |
| sWdata | input | 32 | Write data; only bit 0 is used |
| sRdata | output | 32 | Selected bit in bit 0 |
| sReady | output | 1 | One-cycle completion pulse |
| sErr | output | 1 | Error flag, valid with sReady |
| mReq | output | 1 | Master request, held until mReady |
| mAddr | output | 32 | Target byte address |
| mWrite | output | 1 | Master write enable |
| mSize | output | 2 | Master size code |
| mWdata | output | 32 | Write-back data |
| mLock | output | 1 | Bus lock for read-modify-write |
| mRdata | input | 32 | Target read data |
| mReady | input | 1 | Master completion |
| mErr | input | 1 | Master error, valid with mReady |

## Verification
A wrong latched offset or size shows up on `mAddr` and `mSize` at the first master handshake after the request is accepted. A wrong bit index shows up on the write-back data of an alias write, or on `sRdata` when the response pulse arrives. The bench's memory model also catches a wrong sequencer state. That state either causes an extra master access (a write-back after a read error, or any access for a bad address) or causes the lock to fall between the read and the write-back. Both show within a few cycles of the faulty transition.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } bbState_t;

  typedef struct packed {
    logic capture;   // latch the slave request
    logic loadRead;  // latch master read data
    logic setErr;    // flag an error for the response
  } bbStrobe_t;
endpackage

// File: rtl/bitband_dpath.sv
module bitband_dpath
  import bitband_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_WIN  = 2,
  parameter int WIN_BITS = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] sAddr,
  input  logic              sWrite,
  input  logic [1:0]        sSize,
  input  logic              sSetBit,
  input  logic [DATA_W-1:0] mRdata,
  output logic              reqOk,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [1:0]        mSize,
  output logic [DATA_W-1:0] mWdata,
  output logic [DATA_W-1:0] sRdata,
  output logic              sErr
);
  localparam int BIDX_W    = $clog2(DATA_W);
  localparam int BIT_SHIFT = $clog2(8 * 4);

  logic [NUM_WIN-1:0] winHit;
  logic [ADDR_W-1:0]  baseNext;

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : gWin
      assign winHit[w] = (sAddr[ADDR_W-1:WIN_BITS] == ALIAS_BASE[w][ADDR_W-1:WIN_BITS]);
    end
  endgenerate

  always_comb begin
    baseNext = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (winHit[i]) baseNext = TARGET_BASE[i];
  end

  assign reqOk = (|winHit) && (sSize != 2'd3);

  logic [WIN_BITS-1:0] offQ;
  logic [ADDR_W-1:0]   baseQ;
  logic [1:0]          sizeQ;
  logic                writeQ, setQ, errQ;
  logic [DATA_W-1:0]   rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ   <= '0;
      baseQ  <= '0;
      sizeQ  <= '0;
      writeQ <= 1'b0;
      setQ   <= 1'b0;
      errQ   <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (strobe.capture) begin
        offQ   <= sAddr[WIN_BITS-1:0];
        baseQ  <= baseNext;
        sizeQ  <= sSize;
        writeQ <= sWrite;
        setQ   <= sSetBit;
        errQ   <= strobe.setErr;
      end else if (strobe.setErr) begin
        errQ <= 1'b1;
      end
      if (strobe.loadRead) rdQ <= mRdata;
    end
  end

  logic [BIDX_W-1:0] idxMask, bitIdx;
  logic [ADDR_W-1:0] alignMask;
  logic [DATA_W-1:0] bitSel;

  assign idxMask   = BIDX_W'((8 << sizeQ) - 1);
  assign bitIdx    = offQ[BIDX_W+1:2] & idxMask;
  assign alignMask = ~(ADDR_W'((1 << sizeQ) - 1));
  assign bitSel    = DATA_W'(1) << bitIdx;

  assign mAddr    = (baseQ | ADDR_W'(offQ >> BIT_SHIFT)) & alignMask;
  assign mSize    = sizeQ;
  assign mWdata   = setQ ? (rdQ | bitSel) : (rdQ & ~bitSel);
  assign sRdata   = {{(DATA_W-1){1'b0}}, rdQ[bitIdx] & ~errQ};
  assign sErr     = errQ;
  assign reqWrite = writeQ;
endmodule

// File: rtl/bitband_ctrl.sv
module bitband_ctrl
  import bitband_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sReq,
  input  logic      reqOk,
  input  logic      reqWrite,
  input  logic      mReady,
  input  logic      mErr,
  output bbStrobe_t strobe,
  output logic      mReq,
  output logic      mWrite,
  output logic      mLock,
  output logic      sReady
);
  bbState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (sReq) begin
        strobe.capture = 1'b1;
        if (reqOk) stateNext = ST_READ;
        else begin
          strobe.setErr = 1'b1;
          stateNext     = ST_RESP;
        end
      end
      ST_READ: if (mReady) begin
        if (mErr) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_RESP;
        end else begin
          strobe.loadRead = 1'b1;
          stateNext       = reqWrite ? ST_WRITE : ST_RESP;
        end
      end
      ST_WRITE: if (mReady) begin
        strobe.setErr = mErr;
        stateNext     = ST_RESP;
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign mReq   = (state == ST_READ) || (state == ST_WRITE);
  assign mWrite = (state == ST_WRITE);
  assign mLock  = (state == ST_WRITE) || ((state == ST_READ) && reqWrite);
  assign sReady = (state == ST_RESP);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bitband_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_WIN  = 2,
  parameter int WIN_BITS = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sReq,
  input  logic [ADDR_W-1:0] sAddr,
  input  logic              sWrite,
  input  logic [1:0]        sSize,
  input  logic [DATA_W-1:0] sWdata,
  output logic [DATA_W-1:0] sRdata,
  output logic              sReady,
  output logic              sErr,
  output logic              mReq,
  output logic [ADDR_W-1:0] mAddr,
  output logic              mWrite,
  output logic [1:0]        mSize,
  output logic [DATA_W-1:0] mWdata,
  output logic              mLock,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              mReady,
  input  logic              mErr
);
  bbStrobe_t strobe;
  logic      reqOk, reqWrite;

  bitband_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sReq(sReq), .reqOk(reqOk), .reqWrite(reqWrite),
    .mReady(mReady), .mErr(mErr), .strobe(strobe), .mReq(mReq),
    .mWrite(mWrite), .mLock(mLock), .sReady(sReady)
  );

  bitband_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS),
    .ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sAddr(sAddr), .sWrite(sWrite),
    .sSize(sSize), .sSetBit(sWdata[0]), .mRdata(mRdata), .reqOk(reqOk),
    .reqWrite(reqWrite), .mAddr(mAddr), .mSize(mSize), .mWdata(mWdata),
    .sRdata(sRdata), .sErr(sErr)
  );
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sReq,
  input logic [ADDR_W-1:0] sAddr,
  input logic              sWrite,
  input logic [1:0]        sSize,
  input logic [DATA_W-1:0] sWdata,
  input logic [DATA_W-1:0] sRdata,
  input logic              sReady,
  input logic              sErr,
  input logic              mReq,
  input logic [ADDR_W-1:0] mAddr,
  input logic              mWrite,
  input logic [1:0]        mSize,
  input logic [DATA_W-1:0] mWdata,
  input logic              mLock,
  input logic [DATA_W-1:0] mRdata,
  input logic              mReady,
  input logic              mErr
);
  // R9
  lock_on_writeback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && mWrite) |-> mLock);

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sReady |=> !sReady);

  // R10
  no_ready_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    mReq |-> !sReady);

  // R7
  no_writeback_after_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !mWrite && mReady && mErr) |=> !mReq);

  // R4
  master_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !mReady) |=> (mReq && $stable(mAddr) && $stable(mWrite) && $stable(mSize)));

  // R3
  read_bit_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    sReady |-> (sRdata[DATA_W-1:1] == '0));

  // R4
  writeback_same_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !mWrite && mReady && !mErr && mLock) |=> (mReq && mWrite && $stable(mAddr)));
endmodule

bind bitband_bridge bitband_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (.*);

// File: tb/bitband_bridge_test.sv
module bitband_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [1:0]  s;
    logic [31:0] d;
    logic        lk;
  } op_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sReq = 1'b0, sWrite = 1'b0;
  logic [31:0] sAddr = '0, sWdata = '0;
  logic [1:0]  sSize = '0;
  logic [31:0] sRdata, mAddr, mWdata;
  logic        sReady, sErr, mReq, mWrite, mLock;
  logic [1:0]  mSize;
  logic [31:0] mRdata = '0;
  logic        mReady = 1'b0, mErr = 1'b0;

  int checks = 0, failures = 0, cycles = 0;
  bit busy = 1'b0;

  // memory model state
  logic [7:0] mem [logic [31:0]];
  op_t        ops[$];
  int         lat = 0, cnt = 0;
  bit         errEn = 1'b0, errOnWrite = 1'b0;
  logic [31:0] errAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_bridge uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memRead(input logic [31:0] a, input int sz);
    logic [31:0] v = '0;
    for (int b = 0; b < sz; b++)
      if (mem.exists(a + b)) v |= 32'(mem[a + b]) << (8 * b);
    return v;
  endfunction

  // target memory model, acts between edges
  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      mReady = 1'b0; cnt = 0;
    end else if (mReady) begin
      mReady = 1'b0; mErr = 1'b0;
    end else if (mReq) begin
      if (cnt < lat) cnt++;
      else begin
        op_t o;
        int sz;
        cnt = 0;
        o.w = mWrite; o.a = mAddr; o.s = mSize; o.d = mWdata; o.lk = mLock;
        ops.push_back(o);
        sz = 1 << mSize;
        mErr = errEn && (mAddr == errAddr) && (mWrite == errOnWrite);
        if (!mWrite) mRdata = memRead(mAddr, sz);
        else begin
          mRdata = '0;
          if (!mErr) for (int b = 0; b < sz; b++) mem[mAddr + b] = mWdata[8*b +: 8];
        end
        mReady = 1'b1;
      end
    end
  end

  // per-clock monitor: nothing on either port when idle (R10, R11)
  always @(negedge clk) begin
    if (rstN && !busy) begin
      check(!sReady && !mReq, "R10 idle ports quiet", {30'b0, sReady, mReq}, 32'h0);
    end
  end

  task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output bit er);
    int t = 0;
    @(negedge clk);
    busy = 1'b1;
    sReq = 1'b1; sAddr = a; sWrite = wr; sSize = sz; sWdata = wd;
    do begin
      @(negedge clk);
      t++;
    end while (!sReady && t < 100);
    rd = sRdata; er = sErr;
    sReq = 1'b0;
    check(t < 100, "R10 response arrives", t, 100);
    @(negedge clk);
    check(!sReady, "R10 single-cycle pulse", {31'b0, sReady}, 32'h0);
    busy = 1'b0;
  endtask

  // kind: 0 normal, 1 bad request, 2 read error, 3 write-back error
  task automatic run(input logic [31:0] a, input bit wr, input logic [1:0] szc,
                     input logic [31:0] wd, input int kind, input string tag);
    logic [31:0] base, ta, oldV, newV, rd;
    int bytes, bi;
    bit er;
    base  = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
    bytes = 1 << szc;
    ta    = (base | ((a & 32'h01FF_FFFF) >> 5)) & ~(32'(bytes) - 1);
    bi    = int'((a >> 2) & (32'(8 * bytes) - 1));
    oldV  = memRead(ta, bytes);
    newV  = wd[0] ? (oldV | (32'h1 << bi)) : (oldV & ~(32'h1 << bi));
    errAddr = ta;
    errEn = (kind >= 2);
    errOnWrite = (kind == 3);
    ops.delete();
    access(a, wr, szc, wd, rd, er);
    errEn = 1'b0;
    if (kind == 1) begin
      check(er, {tag, " error flag"}, {31'b0, er}, 32'h1);
      check(ops.size() == 0, {tag, " no master access"}, ops.size(), 0);
      check(rd == 0, {tag, " R10 zero data on error"}, rd, 0);
      return;
    end
    check(ops.size() >= 1, {tag, " R1 master read issued"}, ops.size(), 1);
    if (ops.size() == 0) return;
    check(!ops[0].w && ops[0].a == ta, {tag, " R1 R2 read address"}, ops[0].a, ta);
    check(ops[0].s == szc, {tag, " R2 size"}, ops[0].s, szc);
    check(ops[0].lk == wr, {tag, " R9 lock on read"}, ops[0].lk, wr);
    if (kind == 2) begin
      check(er && ops.size() == 1, {tag, " R7 read error, no write-back"}, ops.size(), 1);
      check(memRead(ta, bytes) == oldV, {tag, " R7 memory unchanged"}, memRead(ta, bytes), oldV);
    end else if (!wr) begin
      check(!er && ops.size() == 1, {tag, " R3 single read"}, ops.size(), 1);
      check(rd == {31'b0, oldV[bi]}, {tag, " R3 read bit"}, rd, {31'b0, oldV[bi]});
    end else begin
      check(ops.size() == 2, {tag, " R4 read then write"}, ops.size(), 2);
      if (ops.size() == 2) begin
        check(ops[1].w && ops[1].a == ta && ops[1].s == szc, {tag, " R4 write-back target"}, ops[1].a, ta);
        check(ops[1].d == newV, {tag, " R4 R5 write-back data"}, ops[1].d, newV);
        check(ops[1].lk, {tag, " R9 lock on write-back"}, {31'b0, ops[1].lk}, 32'h1);
      end
      if (kind == 3) begin
        check(er, {tag, " R8 write-back error"}, {31'b0, er}, 32'h1);
        check(memRead(ta, bytes) == oldV, {tag, " R8 memory unchanged"}, memRead(ta, bytes), oldV);
      end else begin
        check(!er, {tag, " R4 no error"}, {31'b0, er}, 32'h0);
        check(memRead(ta, bytes) == newV, {tag, " R4 memory updated"}, memRead(ta, bytes), newV);
      end
    end
  endtask

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    mem[32'h2000_0010] = 8'h08;
    mem[32'h2000_0011] = 8'hA5;
    mem[32'h4000_0100] = 8'h3C;
    mem[32'h4000_0103] = 8'h80;
    mem[32'h200F_FFFF] = 8'hFF;
    repeat (3) @(negedge clk);
    check(!sReady && !mReq && !mLock, "R12 reset outputs low", {29'b0, sReady, mReq, mLock}, 0);
    rstN = 1'b1;

    lat = 0;
    run(32'h2200_020C, 0, 2'd0, 0, 0, "R3 byte read set bit");
    run(32'h2200_0208, 0, 2'd0, 0, 0, "R3 byte read clear bit");
    run(32'h4200_207C, 0, 2'd2, 0, 0, "R1 window1 word read bit31");
    run(32'h2200_023C, 0, 2'd1, 0, 0, "R2 halfword read upper byte");
    lat = 2;
    run(32'h2200_0204, 1, 2'd0, 32'h0000_0001, 0, "R4 byte write set");
    run(32'h2200_0200, 1, 2'd1, 32'hFFFF_FFFE, 0, "R5 halfword clear with high bits");
    run(32'h4200_2000, 1, 2'd2, 32'h8000_0001, 0, "R5 word set bit0");
    run(32'h4200_2060, 1, 2'd2, 32'h0000_0000, 0, "R4 word clear");
    run(32'h23FF_FFFC, 0, 2'd2, 0, 0, "R2 last window word");
    run(32'h23FF_FFFC, 1, 2'd0, 0, 0, "R2 last window byte write");
    run(32'h2200_0000, 0, 2'd3, 0, 1, "R6 illegal size");
    run(32'h3000_0000, 0, 2'd0, 0, 1, "R11 outside windows");
    run(32'h2400_0000, 1, 2'd0, 1, 1, "R11 just past window");
    lat = 1;
    run(32'h2200_0210, 1, 2'd0, 1, 2, "R7 read error on write");
    run(32'h4200_0010, 0, 2'd2, 0, 2, "R7 read error on read");
    run(32'h2200_0214, 1, 2'd1, 1, 3, "R8 write-back error");

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = {(seed[31] ? 7'h21 : 7'h11), 13'b0, seed[11:0]};
      lat = int'(seed[14:13]);
      run(a, seed[16], (seed[18:17] == 2'd3) ? 2'd2 : seed[18:17], {31'b0, seed[20]}, 0, "R4 mixed traffic");
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule